// File: doc/BRIEF.md
# Flash Byte-Programming Sequencer

This block is a host-side controller that writes a byte image into one or more flash devices that accept two-cycle commands. Once started, it turns on the programming-voltage enable, then visits every address from zero up to the top of the address space. For each byte it fetches the data from a source port indexed by the current address, sends a program-setup command followed by the address and data write, waits a fixed program interval, sends a program-verify command, waits a fixed verify interval and reads the byte back for comparison.

A byte that reads back correctly on every device moves the sequencer to the next address with a fresh attempt count. A byte that misreads on any device is pulsed again, up to a fixed attempt limit; when the limit is reached without a match the run stops with a failure. When several devices share the address and strobe lines with separate data lanes, a device that has already verified the current byte is sent neutral codes in place of the setup, program and verify commands so that it is not over-programmed. Wait intervals are counted in clock cycles derived from a clock-frequency parameter.

Top module: `flash_prog_seq`

## Requirements
- R1: `vpp_en` rises in the same cycle as the first setup write of a run, stays high through the last read, and is low from the cycle in which `done` is high until the next run.
- R2: Each attempt opens with a write carrying 40H on every unverified lane, followed in the next cycle by a write carrying the source byte, with `src_addr` equal to the current byte address.
- R3: After the data write, exactly `CLK_MHZ*PROG_US` cycles without bus activity pass, then a write carrying C0H on unverified lanes, then exactly `CLK_MHZ*VERIFY_US` idle cycles, then a single read cycle; writes and reads never overlap.
- R4: Addresses advance by one from 0 to 2^ADDR_W-1; every bus cycle of an attempt carries the current byte address, and an address advance restarts the attempt count.
- R5: If any unverified lane's read-back differs from the source byte, a new attempt at the same address follows immediately.
- R6: When attempt number `MAX_TRIES` at one address still misreads, the run ends with `done` and `fail` both high and no further bus cycles.
- R7: A lane whose device verified the current byte in an earlier attempt receives FFH instead of 40H, FFH instead of the data, and 00H instead of C0H; its read-back counts as verified.
- R8: `done` is high for exactly one cycle per run; `fail` is low after a successful run, keeps its value after `done`, and clears when the next run starts.
- R9: A `start` pulse while a run is in progress has no effect on the bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run ended on the attempt limit |
| vpp_en | output | 1 | Programming-voltage enable |
| src_addr | output | ADDR_W | Address into the image source |
| src_data | input | 8 | Image byte at `src_addr` |
| bus_wr | output | 1 | Write cycle strobe |
| bus_rd | output | 1 | Read cycle strobe |
| bus_addr | output | ADDR_W | Device address |
| bus_wdata | output | 8*NDEV | Write data, one byte lane per device |
| bus_rdata | input | 8*NDEV | Read data, one byte lane per device, sampled in the read cycle |

## Verification
The assertions watch, on every cycle, that bus activity only happens under the programming-voltage enable, that the enable rises with a write and is down when the run ends, that reads and writes never coincide, that `done` is a single-cycle pulse and that `fail` only moves at the end or start of a run. The exact command order, the wait lengths, the per-lane masking after partial verification, the retry on mismatch and the stop at the attempt limit can only be shown by the bench's scenarios, where a device model with per-byte pulse requirements predicts the full cycle-by-cycle bus trace.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ADDR_W    = 17,
  parameter int NDEV      = 1,
  parameter int CLK_MHZ   = 50,
  parameter int PROG_US   = 25,
  parameter int VERIFY_US = 6,
  parameter int MAX_TRIES = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                done,
  output logic                fail,
  output logic                vpp_en,
  output logic [ADDR_W-1:0]   src_addr,
  input  logic [7:0]          src_data,
  output logic                bus_wr,
  output logic                bus_rd,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [NDEV*8-1:0]   bus_wdata,
  input  logic [NDEV*8-1:0]   bus_rdata
);

  localparam int PROG_CYC = CLK_MHZ * PROG_US;
  localparam int VER_CYC  = CLK_MHZ * VERIFY_US;
  localparam int MAX_CYC  = (PROG_CYC > VER_CYC) ? PROG_CYC : VER_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int TRY_W    = $clog2(MAX_TRIES + 1);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  typedef enum logic [2:0] {IDLE, SETUP, PROG, PWAIT, VCMD, VWAIT, READ} st_t;

  st_t              state;
  logic [ADDR_W-1:0] addr;
  logic [TRY_W-1:0]  tries;
  logic [CNT_W-1:0]  cnt;
  logic [NDEV-1:0]   mask;
  logic [NDEV-1:0]   hit;
  logic              all_ok;

  assign bus_wr   = (state == SETUP) || (state == PROG) || (state == VCMD);
  assign bus_rd   = (state == READ);
  assign bus_addr = addr;
  assign src_addr = addr;
  assign all_ok   = &hit;

  for (genvar d = 0; d < NDEV; d++) begin : g_lane
    assign hit[d] = mask[d] | (bus_rdata[d*8 +: 8] == src_data);
    assign bus_wdata[d*8 +: 8] =
      (state == SETUP) ? (mask[d] ? 8'hFF : 8'h40) :
      (state == PROG)  ? (mask[d] ? 8'hFF : src_data) :
      (state == VCMD)  ? (mask[d] ? 8'h00 : 8'hC0) : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      addr   <= '0;
      tries  <= '0;
      cnt    <= '0;
      mask   <= '0;
      vpp_en <= 1'b0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          vpp_en <= 1'b1;
          fail   <= 1'b0;
          addr   <= '0;
          tries  <= '0;
          mask   <= '0;
          state  <= SETUP;
        end
        SETUP: begin
          tries <= tries + 1'b1;
          state <= PROG;
        end
        PROG: begin
          cnt   <= CNT_W'(PROG_CYC - 1);
          state <= PWAIT;
        end
        PWAIT: if (cnt == '0) state <= VCMD; else cnt <= cnt - 1'b1;
        VCMD: begin
          cnt   <= CNT_W'(VER_CYC - 1);
          state <= VWAIT;
        end
        VWAIT: if (cnt == '0) state <= READ; else cnt <= cnt - 1'b1;
        READ: begin
          if (all_ok && addr != LAST) begin
            addr  <= addr + 1'b1;
            tries <= '0;
            mask  <= '0;
            state <= SETUP;
          end else if (all_ok || tries == TRY_W'(MAX_TRIES)) begin
            done   <= 1'b1;
            fail   <= !all_ok;
            vpp_en <= 1'b0;
            state  <= IDLE;
          end else begin
            mask  <= hit;
            state <= SETUP;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              fail,
  input logic              vpp_en,
  input logic [ADDR_W-1:0] src_addr,
  input logic              bus_wr,
  input logic              bus_rd
);

  assert_bus_under_vpp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> vpp_en);

  assert_vpp_rise_with_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_en) |-> bus_wr);

  assert_vpp_off_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vpp_en);

  assert_no_rw_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  assert_addr_steady_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> $stable(src_addr));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fail_moves_at_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail != $past(fail)) |-> (done || $past(start)));

  assert_done_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(bus_wr || bus_rd));

endmodule

bind flash_prog_seq flash_prog_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
  .vpp_en(vpp_en), .src_addr(src_addr), .bus_wr(bus_wr), .bus_rd(bus_rd)
);

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int ND = 2;
  localparam int MHZ = 1;
  localparam int PUS = 25;
  localparam int VUS = 6;
  localparam int MAXT = 20;
  localparam int NB = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0;
  logic done, fail, vpp_en, bus_wr, bus_rd;
  logic [AW-1:0] src_addr, bus_addr;
  logic [7:0] src_data;
  logic [ND*8-1:0] bus_wdata, bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(.ADDR_W(AW), .NDEV(ND), .CLK_MHZ(MHZ), .PROG_US(PUS),
                   .VERIFY_US(VUS), .MAX_TRIES(MAXT)) u_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
    .vpp_en(vpp_en), .src_addr(src_addr), .src_data(src_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  int checks = 0, failures = 0;
  bit finished = 0;

  // image source and device model: a byte reads correctly once pulsed need[d][a] times
  logic [7:0] img [NB];
  int need   [ND][NB];
  int pulses [ND][NB];
  logic [7:0] cmd [ND];

  assign src_data = img[src_addr];

  always_comb
    for (int d = 0; d < ND; d++)
      bus_rdata[d*8 +: 8] = (pulses[d][bus_addr] >= need[d][bus_addr]) ?
                            img[bus_addr] : (img[bus_addr] ^ 8'h01);

  always @(negedge clk)
    if (rst_n && bus_wr)
      for (int d = 0; d < ND; d++) begin
        if (cmd[d] == 8'h40) begin
          pulses[d][bus_addr] = pulses[d][bus_addr] + 1;
          cmd[d] = 8'h00;
        end else cmd[d] = bus_wdata[d*8 +: 8];
      end

  typedef struct {
    bit wr, rd, vpp, dn, fl;
    logic [AW-1:0] addr;
    logic [ND*8-1:0] wd;
  } rec_t;

  rec_t q[$];

  function automatic rec_t mk(bit wr, bit rd, bit vpp, bit dn, bit fl,
                              int a, logic [ND*8-1:0] wd);
    rec_t r;
    r.wr = wr; r.rd = rd; r.vpp = vpp; r.dn = dn; r.fl = fl;
    r.addr = AW'(a); r.wd = wd;
    return r;
  endfunction

  // expected trace built from the requirements and the device needs
  task automatic build();
    bit bad = 0;
    q.delete();
    for (int a = 0; a < NB && !bad; a++) begin
      int att = 0;
      for (int d = 0; d < ND; d++) if (need[d][a] > att) att = need[d][a];
      for (int k = 1; k <= att && k <= MAXT; k++) begin
        logic [ND*8-1:0] s, p, v;
        for (int d = 0; d < ND; d++) begin
          bit m = (k > need[d][a]);            // R7 masking
          s[d*8 +: 8] = m ? 8'hFF : 8'h40;     // R2
          p[d*8 +: 8] = m ? 8'hFF : img[a];
          v[d*8 +: 8] = m ? 8'h00 : 8'hC0;     // R3
        end
        q.push_back(mk(1, 0, 1, 0, 0, a, s));
        q.push_back(mk(1, 0, 1, 0, 0, a, p));
        for (int i = 0; i < MHZ*PUS; i++) q.push_back(mk(0, 0, 1, 0, 0, a, '0));
        q.push_back(mk(1, 0, 1, 0, 0, a, v));
        for (int i = 0; i < MHZ*VUS; i++) q.push_back(mk(0, 0, 1, 0, 0, a, '0));
        q.push_back(mk(0, 1, 1, 0, 0, a, '0));
      end
      if (att > MAXT) bad = 1;                 // R6
    end
    q.push_back(mk(0, 0, 0, 1, bad, 0, '0));
    q.push_back(mk(0, 0, 0, 0, bad, 0, '0));
    q.push_back(mk(0, 0, 0, 0, bad, 0, '0));
  endtask

  task automatic bad_field(string nm, string req, int i, int act, int exp);
    failures++;
    $display("FAIL %s %s cycle %0d: actual %0h expected %0h", nm, req, i, act, exp);
  endtask

  task automatic cmp(string nm, rec_t e, int i);
    checks++;
    if (vpp_en !== e.vpp) bad_field(nm, "R1 vpp_en", i, vpp_en, e.vpp);
    if (bus_wr !== e.wr || bus_rd !== e.rd)
      bad_field(nm, "R3 R5 strobes", i, {bus_wr, bus_rd}, {e.wr, e.rd});
    if ((e.wr || e.rd) && bus_addr !== e.addr)
      bad_field(nm, "R4 address", i, bus_addr, e.addr);
    if (e.wr && bus_wdata !== e.wd)
      bad_field(nm, "R2 R7 write data", i, bus_wdata, e.wd);
    if (done !== e.dn) bad_field(nm, "R8 done", i, done, e.dn);
    if (e.dn && fail !== e.fl) bad_field(nm, "R6 fail at done", i, fail, e.fl);
    if (!e.dn && fail !== e.fl) bad_field(nm, "R8 fail level", i, fail, e.fl);
  endtask

  task automatic clear_dev(int base);
    for (int d = 0; d < ND; d++) begin
      cmd[d] = 8'h00;
      for (int a = 0; a < NB; a++) begin
        pulses[d][a] = 0;
        need[d][a] = base;
      end
    end
  endtask

  task automatic run(string nm, int poke_at);
    build();
    @(negedge clk);
    start = 1;
    foreach (q[i]) begin
      @(negedge clk);
      start = (i == poke_at);                 // R9: start while busy
      cmp(nm, q[i], i);
    end
    start = 0;
  endtask

  initial begin
    for (int a = 0; a < NB; a++) img[a] = 8'h3C + 8'(a * 8'h17);
    clear_dev(1);
    repeat (3) @(negedge clk);
    checks++;                                  // reset state, R1 R8
    if (vpp_en !== 0 || done !== 0 || fail !== 0 || bus_wr !== 0 || bus_rd !== 0)
      bad_field("reset", "R1 R8 idle outputs", 0,
                {vpp_en, done, fail, bus_wr, bus_rd}, 0);
    rst_n = 1;
    @(negedge clk);

    clear_dev(1);
    run("all-first-try R4", -1);

    clear_dev(1);
    need[0][2] = 3; need[1][5] = 4; need[0][5] = 2; need[0][7] = 2;
    run("retries-masking R5 R7 busy-start R9", 40);

    clear_dev(1);
    need[1][3] = 25; need[0][3] = 2;
    run("attempt-limit R6", -1);

    clear_dev(1);
    need[1][0] = 2;
    run("rerun-after-fail R8", 70);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R6: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end
endmodule